// File: doc/BRIEF.md
# Flash Access Protection Checker

This block sits in the access path of an on-chip non-volatile memory and judges every access in the same cycle it is presented. It returns a permit or a deny verdict with a reason code. The inputs are the access kind, the requester, the byte address and the boot and debug context. The protection settings are held in plain configuration inputs that stand in for option bytes:
- a readout protection level;
- two write-protected windows on 4 KB pages;
- two execute-only windows on 2 KB pages;
- a region on 2 KB pages reserved for the radio processor.

Window bounds are inclusive first and last page indices. A window whose first page is above its last page is switched off.

The block also owns the readout level state. Raising the level takes effect at once. Lowering it from level 1 to level 0 launches a one-cycle mass-erase request, which carries a flag telling the eraser whether to include the execute-only windows. The drop then waits for an erase-done acknowledge. Level 2 can never be left, and any attempt to change it is refused and leaves a sticky error flag.

Every denied access produces a one-cycle fault pulse. The first failing address, requester and reason are held in a record until software clears it.

Top module: `flash_prot_chk`

## Requirements
- R1: After reset the readout level is 0, and no fault record, fault pulse, erase request or level error is present.
- R2: Access kind is coded 0 fetch, 1 read, 2 write, 3 erase. Requester is coded 0 application CPU, 1 radio CPU, 2 DMA, 3 debug. At level 0, with no window hit, every kind from every requester is permitted. While acc_valid is high exactly one of acc_permit and acc_deny is high, and while it is low both are low.
- R3: At level 1, while debug is attached, or boot_sel is nonzero (non-flash boot), or the requester is debug, every access is denied with reason 1 (readout).
- R4: At level 2, debug requests are denied with reason 1, while dbg_attached and boot_sel have no effect on other requesters. The level stays 2, and any level write there is ignored and sets lvl_err, which stays set until reset.
- R5: A write (2) or erase (3) whose 4 KB page addr[ADDR_W-1:12] lies inside a write-protected window is denied with reason 4. Fetches and reads there are permitted.
- R6: Inside an execute-only window (2 KB page addr[ADDR_W-1:11]), only fetches by the application or radio CPU are permitted. Any other kind or requester is denied with reason 3.
- R7: Inside the reserved region (2 KB pages), any requester other than the radio CPU is denied with reason 2.
- R8: Window bounds are inclusive, so first equal to last covers one page. A window with first greater than last matches nothing.
- R9: When several rules deny, the reason reported is the first in the order readout (1), reserved region (2), execute-only (3), write protection (4). Reason 0 means permitted.
- R10: A level write with lvl_code 1 or 2 that raises the level takes effect on the next clock edge. Writes to the current level, and writes with code 3, change nothing.
- R11: A write of code 0 at level 1 raises erase_req for exactly one cycle after the write edge, with erase_incl_xo equal to xo_erase_en at the write. The level stays 1, with all level 1 rules applied, until erase_done is seen. It becomes 0 one edge after that. Level writes while the drop is pending are ignored.
- R12: A denied access raises fault_pulse for the one cycle after it. The record (address, requester, reason) is captured when none is held or when flt_clr is high in the same cycle. Otherwise the first record is kept. flt_clr alone empties the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_type | input | 2 | Access kind (R2 coding) |
| acc_src | input | 2 | Requester (R2 coding) |
| acc_addr | input | ADDR_W | Byte address |
| dbg_attached | input | 1 | Debug probe connected |
| boot_sel | input | 2 | Boot source, 0 = flash, other = SRAM or loader |
| wp_first | input | NUM_WP x (ADDR_W-WP_SHIFT) | First page of each write-protected window |
| wp_last | input | NUM_WP x (ADDR_W-WP_SHIFT) | Last page of each write-protected window |
| xo_first | input | NUM_XO x (ADDR_W-XO_SHIFT) | First page of each execute-only window |
| xo_last | input | NUM_XO x (ADDR_W-XO_SHIFT) | Last page of each execute-only window |
| sec_first | input | ADDR_W-XO_SHIFT | First page of the radio-only region |
| sec_last | input | ADDR_W-XO_SHIFT | Last page of the radio-only region |
| xo_erase_en | input | 1 | Include execute-only windows in a regression erase |
| lvl_wr | input | 1 | Level change request strobe |
| lvl_code | input | 2 | Requested level |
| erase_done | input | 1 | Mass erase finished |
| flt_clr | input | 1 | Clear the fault record |
| acc_permit | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| deny_why | output | 3 | Reason code (R9) |
| fault_pulse | output | 1 | One-cycle pulse after a denial |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | ADDR_W | Recorded address |
| flt_src | output | 2 | Recorded requester |
| flt_why | output | 3 | Recorded reason |
| rdp_level | output | 2 | Effective readout level |
| erase_req | output | 1 | Mass-erase request pulse |
| erase_incl_xo | output | 1 | Erase also covers execute-only windows |
| lvl_err | output | 1 | Sticky refused-change flag |

## Verification
A software clear of the fault record and a new denial can land on the same clock edge. The bench provokes this by raising flt_clr while a denied access is presented and a different record is already held. It then judges that the new address, requester and reason are held with the record still valid. A second collision puts an access on the same edge as a level change or as a pending erase. The bench checks that the verdict follows the level in force before the edge.

// File: rtl/fap_pkg.sv
package fap_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_APP   = 2'd0,
    SRC_RADIO = 2'd1,
    SRC_DMA   = 2'd2,
    SRC_DBG   = 2'd3
  } acc_src_e;

  typedef enum logic [2:0] {
    WHY_NONE = 3'd0,
    WHY_RDP  = 3'd1,
    WHY_SEC  = 3'd2,
    WHY_XO   = 3'd3,
    WHY_WP   = 3'd4
  } deny_why_e;

  typedef enum logic [1:0] {
    ST_L0   = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DROP = 2'd3
  } lvl_state_e;

  localparam logic [1:0] LVL_OPEN = 2'd0;
  localparam logic [1:0] LVL_READ = 2'd1;
  localparam logic [1:0] LVL_CHIP = 2'd2;

endpackage

// File: rtl/fap_window.sv
module fap_window #(
  parameter int ADDR_W = 19,
  parameter int SHIFT  = 11
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-SHIFT-1:0] first_pg,
  input  logic [ADDR_W-SHIFT-1:0] last_pg,
  output logic                    hit
);
  localparam int IDX_W = ADDR_W - SHIFT;

  logic [IDX_W-1:0] page;
  logic             enabled;

  assign page    = addr[ADDR_W-1:SHIFT];
  assign enabled = (first_pg <= last_pg);
  assign hit     = enabled && (page >= first_pg) && (page <= last_pg);

endmodule

// File: rtl/fap_verdict.sv
module fap_verdict
  import fap_pkg::*;
(
  input  logic       acc_valid,
  input  logic [1:0] acc_type,
  input  logic [1:0] acc_src,
  input  logic [1:0] level,
  input  logic       dbg_attached,
  input  logic [1:0] boot_sel,
  input  logic       sec_hit,
  input  logic       xo_hit,
  input  logic       wp_hit,
  output logic       permit,
  output logic       deny,
  output logic [2:0] why
);
  acc_kind_e kind;
  acc_src_e  src;
  deny_why_e rule;
  logic      intrude;
  logic      cpu_fetch;
  logic      modifies;

  assign kind = acc_kind_e'(acc_type);
  assign src  = acc_src_e'(acc_src);

  always_comb begin
    intrude = 1'b0;
    if (level == LVL_READ) begin
      intrude = dbg_attached || (boot_sel != 2'd0) || (src == SRC_DBG);
    end else if (level == LVL_CHIP) begin
      intrude = (src == SRC_DBG);
    end
  end

  assign cpu_fetch = (kind == ACC_FETCH) && ((src == SRC_APP) || (src == SRC_RADIO));
  assign modifies  = (kind == ACC_WRITE) || (kind == ACC_ERASE);

  always_comb begin
    rule = WHY_NONE;
    if (intrude) begin
      rule = WHY_RDP;
    end else if (sec_hit && (src != SRC_RADIO)) begin
      rule = WHY_SEC;
    end else if (xo_hit && !cpu_fetch) begin
      rule = WHY_XO;
    end else if (wp_hit && modifies) begin
      rule = WHY_WP;
    end
  end

  assign permit = acc_valid && (rule == WHY_NONE);
  assign deny   = acc_valid && (rule != WHY_NONE);
  assign why    = acc_valid ? rule : WHY_NONE;

endmodule

// File: rtl/fap_level_ctrl.sv
module fap_level_ctrl
  import fap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_wr,
  input  logic [1:0] lvl_code,
  input  logic       xo_erase_en,
  input  logic       erase_done,
  output logic [1:0] level,
  output logic       erase_req,
  output logic       erase_incl_xo,
  output logic       lvl_err
);
  lvl_state_e st_q, st_d;
  logic       req_q, req_d;
  logic       incl_q, incl_d, incl_en;
  logic       err_q, err_d;

  always_comb begin
    st_d    = st_q;
    req_d   = 1'b0;
    incl_d  = incl_q;
    incl_en = 1'b0;
    err_d   = err_q;
    case (st_q)
      ST_L0: begin
        if (lvl_wr) begin
          if (lvl_code == LVL_READ) begin
            st_d = ST_L1;
          end else if (lvl_code == LVL_CHIP) begin
            st_d = ST_L2;
          end
        end
      end
      ST_L1: begin
        if (lvl_wr) begin
          if (lvl_code == LVL_OPEN) begin
            st_d    = ST_DROP;
            req_d   = 1'b1;
            incl_d  = xo_erase_en;
            incl_en = 1'b1;
          end else if (lvl_code == LVL_CHIP) begin
            st_d = ST_L2;
          end
        end
      end
      ST_DROP: begin
        if (erase_done) begin
          st_d = ST_L0;
        end
      end
      ST_L2: begin
        if (lvl_wr) begin
          err_d = 1'b1;
        end
      end
      default: st_d = ST_L0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_L0;
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incl_q <= 1'b0;
    end else if (incl_en) begin
      incl_q <= incl_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_L0:   level = LVL_OPEN;
      ST_L2:   level = LVL_CHIP;
      default: level = LVL_READ;
    endcase
  end

  assign erase_req     = req_q;
  assign erase_incl_xo = incl_q;
  assign lvl_err       = err_q;

endmodule

// File: rtl/fap_fault_rec.sv
module fap_fault_rec #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        src,
  input  logic [2:0]        why,
  input  logic              clr,
  output logic              pulse,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [1:0]        rec_src,
  output logic [2:0]        rec_why
);
  logic              pulse_q;
  logic              valid_q, valid_d;
  logic              capture;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        src_q;
  logic [2:0]        why_q;

  assign capture = deny && (!valid_q || clr);

  always_comb begin
    valid_d = valid_q;
    if (capture) begin
      valid_d = 1'b1;
    end else if (clr) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pulse_q <= deny;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      src_q  <= '0;
      why_q  <= '0;
    end else if (capture) begin
      addr_q <= addr;
      src_q  <= src;
      why_q  <= why;
    end
  end

  assign pulse     = pulse_q;
  assign rec_valid = valid_q;
  assign rec_addr  = addr_q;
  assign rec_src   = src_q;
  assign rec_why   = why_q;

endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk
  import fap_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WP_SHIFT = 12,
  parameter int XO_SHIFT = 11,
  parameter int NUM_WP   = 2,
  parameter int NUM_XO   = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   acc_valid,
  input  logic [1:0]                             acc_type,
  input  logic [1:0]                             acc_src,
  input  logic [ADDR_W-1:0]                      acc_addr,
  input  logic                                   dbg_attached,
  input  logic [1:0]                             boot_sel,
  input  logic [NUM_WP-1:0][ADDR_W-WP_SHIFT-1:0] wp_first,
  input  logic [NUM_WP-1:0][ADDR_W-WP_SHIFT-1:0] wp_last,
  input  logic [NUM_XO-1:0][ADDR_W-XO_SHIFT-1:0] xo_first,
  input  logic [NUM_XO-1:0][ADDR_W-XO_SHIFT-1:0] xo_last,
  input  logic [ADDR_W-XO_SHIFT-1:0]             sec_first,
  input  logic [ADDR_W-XO_SHIFT-1:0]             sec_last,
  input  logic                                   xo_erase_en,
  input  logic                                   lvl_wr,
  input  logic [1:0]                             lvl_code,
  input  logic                                   erase_done,
  input  logic                                   flt_clr,
  output logic                                   acc_permit,
  output logic                                   acc_deny,
  output logic [2:0]                             deny_why,
  output logic                                   fault_pulse,
  output logic                                   flt_valid,
  output logic [ADDR_W-1:0]                      flt_addr,
  output logic [1:0]                             flt_src,
  output logic [2:0]                             flt_why,
  output logic [1:0]                             rdp_level,
  output logic                                   erase_req,
  output logic                                   erase_incl_xo,
  output logic                                   lvl_err
);
  logic [NUM_WP-1:0] wp_hits;
  logic [NUM_XO-1:0] xo_hits;
  logic              sec_hit;
  logic [1:0]        level;
  logic              deny_w;
  logic [2:0]        why_w;

  for (genvar gw = 0; gw < NUM_WP; gw++) begin : g_wp
    fap_window #(.ADDR_W(ADDR_W), .SHIFT(WP_SHIFT)) u_win (
      .addr     (acc_addr),
      .first_pg (wp_first[gw]),
      .last_pg  (wp_last[gw]),
      .hit      (wp_hits[gw])
    );
  end

  for (genvar gx = 0; gx < NUM_XO; gx++) begin : g_xo
    fap_window #(.ADDR_W(ADDR_W), .SHIFT(XO_SHIFT)) u_win (
      .addr     (acc_addr),
      .first_pg (xo_first[gx]),
      .last_pg  (xo_last[gx]),
      .hit      (xo_hits[gx])
    );
  end

  fap_window #(.ADDR_W(ADDR_W), .SHIFT(XO_SHIFT)) u_sec_win (
    .addr     (acc_addr),
    .first_pg (sec_first),
    .last_pg  (sec_last),
    .hit      (sec_hit)
  );

  fap_level_ctrl u_level (
    .clk           (clk),
    .rst_n         (rst_n),
    .lvl_wr        (lvl_wr),
    .lvl_code      (lvl_code),
    .xo_erase_en   (xo_erase_en),
    .erase_done    (erase_done),
    .level         (level),
    .erase_req     (erase_req),
    .erase_incl_xo (erase_incl_xo),
    .lvl_err       (lvl_err)
  );

  fap_verdict u_verdict (
    .acc_valid    (acc_valid),
    .acc_type     (acc_type),
    .acc_src      (acc_src),
    .level        (level),
    .dbg_attached (dbg_attached),
    .boot_sel     (boot_sel),
    .sec_hit      (sec_hit),
    .xo_hit       (|xo_hits),
    .wp_hit       (|wp_hits),
    .permit       (acc_permit),
    .deny         (deny_w),
    .why          (why_w)
  );

  fap_fault_rec #(.ADDR_W(ADDR_W)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .deny      (deny_w),
    .addr      (acc_addr),
    .src       (acc_src),
    .why       (why_w),
    .clr       (flt_clr),
    .pulse     (fault_pulse),
    .rec_valid (flt_valid),
    .rec_addr  (flt_addr),
    .rec_src   (flt_src),
    .rec_why   (flt_why)
  );

  assign acc_deny  = deny_w;
  assign deny_why  = why_w;
  assign rdp_level = level;

endmodule

// File: rtl/flash_prot_chk_sva.sv
module flash_prot_chk_sva #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_permit,
  input logic              acc_deny,
  input logic              fault_pulse,
  input logic              flt_clr,
  input logic              flt_valid,
  input logic [ADDR_W-1:0] flt_addr,
  input logic [1:0]        flt_src,
  input logic [2:0]        flt_why,
  input logic [1:0]        rdp_level,
  input logic              lvl_wr,
  input logic              erase_req,
  input logic              erase_done,
  input logic              lvl_err
);

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_permit ^ acc_deny));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_permit && !acc_deny));

  p_chip_level_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_level == 2'd2) |=> (rdp_level == 2'd2));

  p_chip_write_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_level == 2'd2 && lvl_wr) |=> lvl_err);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_err |=> lvl_err);

  p_erase_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  p_drop_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdp_level == 2'd0 && $past(rdp_level) == 2'd1) |-> $past(erase_done));

  p_fault_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_deny) |=> fault_pulse);

  p_no_spurious_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_deny) |=> !fault_pulse);

  p_record_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clr) |=>
      (flt_valid && $stable(flt_addr) && $stable(flt_src) && $stable(flt_why)));

endmodule

bind flash_prot_chk flash_prot_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_permit  (acc_permit),
  .acc_deny    (acc_deny),
  .fault_pulse (fault_pulse),
  .flt_clr     (flt_clr),
  .flt_valid   (flt_valid),
  .flt_addr    (flt_addr),
  .flt_src     (flt_src),
  .flt_why     (flt_why),
  .rdp_level   (rdp_level),
  .lvl_wr      (lvl_wr),
  .erase_req   (erase_req),
  .erase_done  (erase_done),
  .lvl_err     (lvl_err)
);

// File: tb/flash_prot_chk_tb.sv
module flash_prot_chk_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 19;

  logic            clk;
  logic            rst_n;
  logic            acc_valid;
  logic [1:0]      acc_type;
  logic [1:0]      acc_src;
  logic [AW-1:0]   acc_addr;
  logic            dbg_attached;
  logic [1:0]      boot_sel;
  logic [1:0][6:0] wp_first, wp_last;
  logic [1:0][7:0] xo_first, xo_last;
  logic [7:0]      sec_first, sec_last;
  logic            xo_erase_en;
  logic            lvl_wr;
  logic [1:0]      lvl_code;
  logic            erase_done;
  logic            flt_clr;
  logic            acc_permit, acc_deny;
  logic [2:0]      deny_why;
  logic            fault_pulse, flt_valid;
  logic [AW-1:0]   flt_addr;
  logic [1:0]      flt_src;
  logic [2:0]      flt_why;
  logic [1:0]      rdp_level;
  logic            erase_req, erase_incl_xo, lvl_err;

  int n_chk  = 0;
  int n_fail = 0;

  flash_prot_chk #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
    .acc_src(acc_src), .acc_addr(acc_addr), .dbg_attached(dbg_attached),
    .boot_sel(boot_sel), .wp_first(wp_first), .wp_last(wp_last),
    .xo_first(xo_first), .xo_last(xo_last), .sec_first(sec_first),
    .sec_last(sec_last), .xo_erase_en(xo_erase_en), .lvl_wr(lvl_wr),
    .lvl_code(lvl_code), .erase_done(erase_done), .flt_clr(flt_clr),
    .acc_permit(acc_permit), .acc_deny(acc_deny), .deny_why(deny_why),
    .fault_pulse(fault_pulse), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_src(flt_src), .flt_why(flt_why), .rdp_level(rdp_level),
    .erase_req(erase_req), .erase_incl_xo(erase_incl_xo), .lvl_err(lvl_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic probe(input string tag, input logic [1:0] ty, input logic [1:0] src,
                       input logic [AW-1:0] a, input logic ok, input logic [2:0] why);
    @(negedge clk);
    acc_valid = 1'b1; acc_type = ty; acc_src = src; acc_addr = a;
    #1;
    chk({tag, " verdict"}, {30'd0, acc_permit, acc_deny}, ok ? 32'd2 : 32'd1);
    chk({tag, " reason"}, {29'd0, deny_why}, {29'd0, why});
  endtask

  task automatic lvl_write(input logic [1:0] code);
    @(negedge clk);
    lvl_wr = 1'b1; lvl_code = code;
    @(negedge clk);
    lvl_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 level", {30'd0, rdp_level}, 32'd0);
    chk("R1 record", {31'd0, flt_valid}, 32'd0);
    chk("R1 pulse", {31'd0, fault_pulse}, 32'd0);
    chk("R1 erase", {31'd0, erase_req}, 32'd0);
    chk("R1 error", {31'd0, lvl_err}, 32'd0);
  endtask

  task automatic t_open;
    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 4; s++) begin
        probe("R2 open", 2'(t), 2'(s), 19'h01000, 1'b1, 3'd0);
      end
    end
    @(negedge clk); acc_valid = 1'b0; #1;
    chk("R2 idle", {30'd0, acc_permit, acc_deny}, 32'd0);
  endtask

  task automatic t_wp;
    wp_first[0] = 7'd2; wp_last[0] = 7'd3;
    probe("R5 write in", 2'd2, 2'd0, 19'h02000, 1'b0, 3'd4);
    probe("R5 erase in", 2'd3, 2'd2, 19'h03FFC, 1'b0, 3'd4);
    probe("R5 read in",  2'd1, 2'd0, 19'h02000, 1'b1, 3'd0);
    probe("R5 fetch in", 2'd0, 2'd0, 19'h03000, 1'b1, 3'd0);
    probe("R8 write above", 2'd2, 2'd0, 19'h04000, 1'b1, 3'd0);
    probe("R8 write below", 2'd2, 2'd0, 19'h01FFF, 1'b1, 3'd0);
  endtask

  task automatic t_xo;
    xo_first[0] = 8'd16; xo_last[0] = 8'd17;
    probe("R6 app fetch",   2'd0, 2'd0, 19'h08000, 1'b1, 3'd0);
    probe("R6 radio fetch", 2'd0, 2'd1, 19'h08FFC, 1'b1, 3'd0);
    probe("R6 app read",    2'd1, 2'd0, 19'h08000, 1'b0, 3'd3);
    probe("R6 dma read",    2'd1, 2'd2, 19'h08800, 1'b0, 3'd3);
    probe("R6 dbg fetch",   2'd0, 2'd3, 19'h08000, 1'b0, 3'd3);
    probe("R6 app write",   2'd2, 2'd0, 19'h08000, 1'b0, 3'd3);
    xo_first[1] = 8'd20; xo_last[1] = 8'd20;
    probe("R8 single page", 2'd1, 2'd0, 19'h0A7FF, 1'b0, 3'd3);
    probe("R8 next page",   2'd1, 2'd0, 19'h0A800, 1'b1, 3'd0);
    xo_first[1] = 8'd21;
    probe("R8 disabled",    2'd1, 2'd0, 19'h0A000, 1'b1, 3'd0);
  endtask

  task automatic t_sec;
    sec_first = 8'd200; sec_last = 8'd255;
    probe("R7 app read",   2'd1, 2'd0, 19'h64000, 1'b0, 3'd2);
    probe("R7 radio read", 2'd1, 2'd1, 19'h64000, 1'b1, 3'd0);
    probe("R7 dma read",   2'd1, 2'd2, 19'h7FFFC, 1'b0, 3'd2);
    probe("R7 app below",  2'd1, 2'd0, 19'h63FFF, 1'b1, 3'd0);
  endtask

  task automatic t_prio;
    wp_first[1] = 7'd8; wp_last[1] = 7'd8;
    probe("R9 xo over wp", 2'd2, 2'd0, 19'h08000, 1'b0, 3'd3);
    wp_first[1] = 7'd100; wp_last[1] = 7'd127;
    probe("R9 sec over wp",  2'd2, 2'd0, 19'h64000, 1'b0, 3'd2);
    probe("R9 radio hits wp", 2'd2, 2'd1, 19'h64000, 1'b0, 3'd4);
    wp_first[1] = 7'd5; wp_last[1] = 7'd4;
    probe("R8 wp off", 2'd2, 2'd1, 19'h64000, 1'b1, 3'd0);
  endtask

  task automatic t_fault;
    @(negedge clk); acc_valid = 1'b0; flt_clr = 1'b1;
    @(negedge clk); flt_clr = 1'b0; #1;
    chk("R12 cleared", {31'd0, flt_valid}, 32'd0);
    probe("R12 deny a", 2'd2, 2'd0, 19'h02000, 1'b0, 3'd4);
    @(posedge clk); #1;
    chk("R12 pulse", {31'd0, fault_pulse}, 32'd1);
    chk("R12 valid", {31'd0, flt_valid}, 32'd1);
    chk("R12 addr", {13'd0, flt_addr}, 32'h02000);
    chk("R12 src", {30'd0, flt_src}, 32'd0);
    chk("R12 why", {29'd0, flt_why}, 32'd4);
    probe("R12 deny b", 2'd1, 2'd2, 19'h08000, 1'b0, 3'd3);
    @(posedge clk); #1;
    chk("R12 first kept addr", {13'd0, flt_addr}, 32'h02000);
    chk("R12 first kept why", {29'd0, flt_why}, 32'd4);
    @(negedge clk); acc_valid = 1'b0;
    @(posedge clk); #1;
    chk("R12 pulse ends", {31'd0, fault_pulse}, 32'd0);
    chk("R12 still held", {31'd0, flt_valid}, 32'd1);
    // clear and a new denial on the same edge
    @(negedge clk); flt_clr = 1'b1;
    acc_valid = 1'b1; acc_type = 2'd1; acc_src = 2'd2; acc_addr = 19'h08004;
    @(posedge clk); #1;
    chk("R12 collide valid", {31'd0, flt_valid}, 32'd1);
    chk("R12 collide addr", {13'd0, flt_addr}, 32'h08004);
    chk("R12 collide src", {30'd0, flt_src}, 32'd2);
    chk("R12 collide why", {29'd0, flt_why}, 32'd3);
    @(negedge clk); acc_valid = 1'b0;
    @(posedge clk); #1;
    chk("R12 clear alone", {31'd0, flt_valid}, 32'd0);
    @(negedge clk); flt_clr = 1'b0;
  endtask

  task automatic t_levels;
    lvl_write(2'd0);
    chk("R10 same level", {30'd0, rdp_level}, 32'd0);
    lvl_write(2'd3);
    chk("R10 code3 at 0", {30'd0, rdp_level}, 32'd0);
    lvl_write(2'd1);
    chk("R10 raise to 1", {30'd0, rdp_level}, 32'd1);
    probe("R3 clean read", 2'd1, 2'd0, 19'h01000, 1'b1, 3'd0);
    dbg_attached = 1'b1;
    probe("R3 dbg attached", 2'd1, 2'd0, 19'h01000, 1'b0, 3'd1);
    probe("R9 rdp over sec", 2'd1, 2'd0, 19'h64000, 1'b0, 3'd1);
    dbg_attached = 1'b0; boot_sel = 2'd2;
    probe("R3 sram boot", 2'd0, 2'd0, 19'h01000, 1'b0, 3'd1);
    boot_sel = 2'd0;
    probe("R3 dbg requester", 2'd1, 2'd3, 19'h01000, 1'b0, 3'd1);
    lvl_write(2'd3);
    chk("R10 code3 at 1", {30'd0, rdp_level}, 32'd1);
    xo_erase_en = 1'b1;
    lvl_write(2'd0);
    chk("R11 erase pulse", {31'd0, erase_req}, 32'd1);
    chk("R11 incl xo", {31'd0, erase_incl_xo}, 32'd1);
    chk("R11 level held", {30'd0, rdp_level}, 32'd1);
    xo_erase_en = 1'b0;
    @(negedge clk); #1;
    chk("R11 pulse one cycle", {31'd0, erase_req}, 32'd0);
    boot_sel = 2'd1;
    probe("R11 pending is level 1", 2'd1, 2'd0, 19'h01000, 1'b0, 3'd1);
    boot_sel = 2'd0;
    lvl_write(2'd2);
    chk("R11 write while pending", {30'd0, rdp_level}, 32'd1);
    chk("R11 no error", {31'd0, lvl_err}, 32'd0);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0; #1;
    chk("R11 drop done", {30'd0, rdp_level}, 32'd0);
    probe("R11 open again", 2'd1, 2'd3, 19'h01000, 1'b1, 3'd0);
    lvl_write(2'd2);
    chk("R10 raise to 2", {30'd0, rdp_level}, 32'd2);
    probe("R4 dbg requester", 2'd1, 2'd3, 19'h01000, 1'b0, 3'd1);
    dbg_attached = 1'b1; boot_sel = 2'd2;
    probe("R4 context ignored", 2'd1, 2'd0, 19'h01000, 1'b1, 3'd0);
    dbg_attached = 1'b0; boot_sel = 2'd0;
    lvl_write(2'd0);
    chk("R4 level kept", {30'd0, rdp_level}, 32'd2);
    chk("R4 error set", {31'd0, lvl_err}, 32'd1);
    chk("R4 no erase", {31'd0, erase_req}, 32'd0);
    @(negedge clk); @(negedge clk); #1;
    chk("R4 error sticky", {31'd0, lvl_err}, 32'd1);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_type = 2'd0; acc_src = 2'd0; acc_addr = '0;
    dbg_attached = 1'b0; boot_sel = 2'd0;
    wp_first[0] = 7'd1; wp_last[0] = 7'd0; wp_first[1] = 7'd1; wp_last[1] = 7'd0;
    xo_first[0] = 8'd1; xo_last[0] = 8'd0; xo_first[1] = 8'd1; xo_last[1] = 8'd0;
    sec_first = 8'd1; sec_last = 8'd0;
    xo_erase_en = 1'b0; lvl_wr = 1'b0; lvl_code = 2'd0;
    erase_done = 1'b0; flt_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_open();
    t_wp();
    t_xo();
    t_sec();
    t_prio();
    t_fault();
    t_levels();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule